// File: doc/BRIEF.md
# Six-Stage Pipelined AES-128 Encryption Round

This block carries out one AES-128 encryption round and spreads it over six register stages of roughly equal depth. It takes a new 128-bit state with its 128-bit round key on every clock, so up to six independent blocks can be in flight at once. A full encryption runs ten passes through the block, with the output of each pass fed back as the next input. The surrounding logic supplies a fresh round key for each pass and raises the last-round flag on the tenth pass.

The byte substitution uses no lookup table. Each byte's multiplicative inverse in GF(2^8) is found by raising it to the power 254 with a chain of square-and-multiply steps. The affine map follows. The cuts between stages fall inside this chain, so no stage holds a whole S-box. After the substitution come the row rotation, the column mixing (skipped on the final round) and the key XOR. For the first pass, an auxiliary whitening input can be XORed onto the state before substitution. This folds the initial key addition into the first round.

The state is 16 bytes stored column-major: byte index = 4*column + row. Byte 0 occupies bits 127:120, with bit 127 as its MSB. Byte i occupies bits 127-8i down to 120-8i.

Top module: `aes_round_pipe`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, out_valid and out_last are 0 and out_state is all zeros.
- R2: A block accepted with in_valid=1 at a rising edge appears with out_valid=1 exactly six rising edges later. out_valid is 0 at the five edges before that when no other block was accepted.
- R3: out_last equals the in_last value of the block being delivered. out_last is never 1 while out_valid is 0.
- R4: With in_last=0, out_state = MixColumns(ShiftRows(SubBytes(S))) XOR K, where K is in_key. MixColumns multiplies each column by {03}x^3+{01}x^2+{01}x+{02} modulo x^4+1. ShiftRows rotates row r left by r positions. All byte positions follow the column-major order stated above. For S=00102030405060708090a0b0c0d0e0f0 and K=d6aa74fdd2af72fadaa678f1d6ab76fe, the result is 89d810e8855ace682d1843d8cb128fe4.
- R5: With in_last=1, MixColumns is skipped and out_state = ShiftRows(SubBytes(S)) XOR K. For the S of R4 and K=0, the result is 6353e08c0960e104cd70b751bacad0e7.
- R6: With in_first=1, S = in_state XOR in_white. For in_state=00112233445566778899aabbccddeeff, in_white=000102030405060708090a0b0c0d0e0f and the K of R4, the result is 89d810e8855ace682d1843d8cb128fe4.
- R7: With in_first=0, in_white has no effect on out_state.
- R8: Six blocks accepted on consecutive edges leave in the same order on six consecutive edges, each with its own correct round result. out_valid drops on the edge after the sixth.
- R9: Ten passes fed back produce ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a. The passes use key 000102...0f as whitening and the standard expanded round keys 1 to 10, with in_last=1 on the tenth pass. The plaintext is 00112233...ff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input block present this cycle |
| in_last | input | 1 | Input block is on its final round (column mixing skipped) |
| in_first | input | 1 | XOR in_white onto the state before substitution |
| in_state | input | 128 | Round input state, column-major |
| in_white | input | 128 | Whitening key used when in_first is 1 |
| in_key | input | 128 | Round key for this pass |
| out_valid | output | 1 | Result block present this cycle |
| out_last | output | 1 | Final-round flag of the result block |
| out_state | output | 128 | Round result state |

## Verification
The block is built with its default stage split: one power step in the first stage, two in each of the second and third, and one in the fourth before the squaring and affine map. This split gives the latency of six. With it, the bench can check exact timing edge by edge and can keep six blocks in flight at once. The published test vector checks the normal round, the final-round bypass and the whitening path in isolation. A ten-pass feedback encryption against the known ciphertext then checks all of them together, along with the byte ordering.

// File: rtl/aes_rp_pkg.sv
package aes_rp_pkg;

    localparam int NUM_BYTES  = 16;
    localparam int STATE_W    = 8 * NUM_BYTES;
    localparam int ST1_STEPS  = 1;
    localparam int ST2_STEPS  = 2;
    localparam int ST3_STEPS  = 2;
    localparam int ST4_STEPS  = 1;
    localparam int PIPE_DEPTH = 6;

    // GF(2^8) product reduced by x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] sbox_affine(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = v[i] ^ v[(i + 4) % 8] ^ v[(i + 5) % 8]
                 ^ v[(i + 6) % 8] ^ v[(i + 7) % 8];
        end
        return r ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes_pow_step.sv
module aes_pow_step
    import aes_rp_pkg::*;
#(
    parameter int STEPS = 1
) (
    input  logic [STATE_W-1:0] base,
    input  logic [STATE_W-1:0] part,
    output logic [STATE_W-1:0] result
);
    // each step maps p to p*p*x: x^1 -> x^3 -> x^7 -> ... -> x^127
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        localparam int HI = STATE_W - 1 - 8 * g;
        always_comb begin
            logic [7:0] acc;
            acc = part[HI -: 8];
            for (int s = 0; s < STEPS; s++) begin
                acc = gf_mul(gf_mul(acc, acc), base[HI -: 8]);
            end
            result[HI -: 8] = acc;
        end
    end
endmodule

// File: rtl/aes_sbox_tail.sv
module aes_sbox_tail
    import aes_rp_pkg::*;
(
    input  logic [STATE_W-1:0] pow127,
    output logic [STATE_W-1:0] subst
);
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        localparam int HI = STATE_W - 1 - 8 * g;
        // x^254 is the inverse (and 0 maps to 0)
        assign subst[HI -: 8] = sbox_affine(gf_mul(pow127[HI -: 8], pow127[HI -: 8]));
    end
endmodule

// File: rtl/aes_mix_layer.sv
module aes_mix_layer
    import aes_rp_pkg::*;
(
    input  logic [STATE_W-1:0] subst,
    input  logic               bypass,
    output logic [STATE_W-1:0] mixed
);
    for (genvar c = 0; c < 4; c++) begin : g_col
        logic [7:0] a [4];
        logic [7:0] m [4];
        for (genvar r = 0; r < 4; r++) begin : g_row
            localparam int SRC = 4 * ((c + r) % 4) + r;
            localparam int DST = 4 * c + r;
            assign a[r] = subst[STATE_W - 1 - 8 * SRC -: 8];
            assign mixed[STATE_W - 1 - 8 * DST -: 8] = bypass ? a[r] : m[r];
        end
        assign m[0] = gf_dbl(a[0]) ^ gf_dbl(a[1]) ^ a[1] ^ a[2] ^ a[3];
        assign m[1] = a[0] ^ gf_dbl(a[1]) ^ gf_dbl(a[2]) ^ a[2] ^ a[3];
        assign m[2] = a[0] ^ a[1] ^ gf_dbl(a[2]) ^ gf_dbl(a[3]) ^ a[3];
        assign m[3] = gf_dbl(a[0]) ^ a[0] ^ a[1] ^ a[2] ^ gf_dbl(a[3]);
    end
endmodule

// File: rtl/aes_round_pipe.sv
module aes_round_pipe
    import aes_rp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_last,
    input  logic               in_first,
    input  logic [STATE_W-1:0] in_state,
    input  logic [STATE_W-1:0] in_white,
    input  logic [STATE_W-1:0] in_key,
    output logic               out_valid,
    output logic               out_last,
    output logic [STATE_W-1:0] out_state
);
    // flags per stage
    logic [PIPE_DEPTH-1:0] vld_q;
    logic [PIPE_DEPTH-1:0] lst_q;

    logic [STATE_W-1:0] x1_q, p1_q, k1_q;
    logic [STATE_W-1:0] x2_q, p2_q, k2_q;
    logic [STATE_W-1:0] x3_q, p3_q, k3_q;
    logic [STATE_W-1:0] s4_q, k4_q;
    logic [STATE_W-1:0] m5_q, k5_q;
    logic [STATE_W-1:0] o6_q;

    logic [STATE_W-1:0] whitened, p1_d, p2_d, p3_d, p4_d, s4_d, m5_d;

    assign whitened = in_first ? (in_state ^ in_white) : in_state;

    aes_pow_step #(.STEPS(ST1_STEPS)) i_pow1 (.base(whitened), .part(whitened), .result(p1_d));
    aes_pow_step #(.STEPS(ST2_STEPS)) i_pow2 (.base(x1_q), .part(p1_q), .result(p2_d));
    aes_pow_step #(.STEPS(ST3_STEPS)) i_pow3 (.base(x2_q), .part(p2_q), .result(p3_d));
    aes_pow_step #(.STEPS(ST4_STEPS)) i_pow4 (.base(x3_q), .part(p3_q), .result(p4_d));
    aes_sbox_tail i_tail (.pow127(p4_d), .subst(s4_d));
    aes_mix_layer i_mix  (.subst(s4_q), .bypass(lst_q[3]), .mixed(m5_d));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            lst_q <= '0;
        end else begin
            vld_q <= {vld_q[PIPE_DEPTH-2:0], in_valid};
            lst_q <= {lst_q[PIPE_DEPTH-2:0], in_valid & in_last};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x1_q <= '0; p1_q <= '0; k1_q <= '0;
            x2_q <= '0; p2_q <= '0; k2_q <= '0;
            x3_q <= '0; p3_q <= '0; k3_q <= '0;
            s4_q <= '0; k4_q <= '0;
            m5_q <= '0; k5_q <= '0;
            o6_q <= '0;
        end else begin
            x1_q <= whitened; p1_q <= p1_d; k1_q <= in_key;
            x2_q <= x1_q;     p2_q <= p2_d; k2_q <= k1_q;
            x3_q <= x2_q;     p3_q <= p3_d; k3_q <= k2_q;
            s4_q <= s4_d;     k4_q <= k3_q;
            m5_q <= m5_d;     k5_q <= k4_q;
            o6_q <= m5_q ^ k5_q;
        end
    end

    assign out_valid = vld_q[PIPE_DEPTH-1];
    assign out_last  = lst_q[PIPE_DEPTH-1];
    assign out_state = o6_q;
endmodule

// File: rtl/aes_round_pipe_chk.sv
module aes_round_pipe_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_last,
    input logic out_valid,
    input logic out_last
);
    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= 3'd0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R1: idle on the first edge after reset release
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd0) |-> (!out_valid && !out_last));

    // R2: valid travels exactly six edges
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd7) |-> (out_valid == $past(in_valid, 6)));

    // R3: last flag stays with its block
    a_r3_last_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd7 && out_valid) |-> (out_last == $past(in_last, 6)));

    // R3: last only with valid
    a_r3_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

bind aes_round_pipe aes_round_pipe_chk i_chk (.*);

// File: tb/test_aes_round_pipe.sv
module test_aes_round_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, in_last = 1'b0, in_first = 1'b0;
    logic [127:0] in_state = '0, in_white = '0, in_key = '0;
    logic         out_valid, out_last;
    logic [127:0] out_state;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    aes_round_pipe i_aes_round_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_first(in_first), .in_state(in_state), .in_white(in_white),
        .in_key(in_key), .out_valid(out_valid), .out_last(out_last),
        .out_state(out_state)
    );

    // ---------- reference model, independent of the design ----------
    function automatic logic [7:0] r_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = 16'h0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] r_sbox(input logic [7:0] x);
        logic [7:0] inv = 8'h00;
        logic [7:0] r;
        for (int y = 1; y < 256; y++) if (r_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        r = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
        return r;
    endfunction

    function automatic logic [7:0] gb(input logic [127:0] s, input int idx);
        return s[127 - 8 * idx -: 8];
    endfunction

    function automatic logic [127:0] r_round(input logic [127:0] s, input logic [127:0] k,
                                             input bit last);
        logic [127:0] t;
        logic [127:0] o;
        logic [7:0] a0, a1, a2, a3;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                t[127 - 8 * (4 * c + r) -: 8] = r_sbox(gb(s, 4 * ((c + r) % 4) + r));
        o = t;
        if (!last) begin
            for (int c = 0; c < 4; c++) begin
                a0 = gb(t, 4 * c); a1 = gb(t, 4 * c + 1);
                a2 = gb(t, 4 * c + 2); a3 = gb(t, 4 * c + 3);
                o[127 - 8 * (4 * c)     -: 8] = r_mul(a0, 2) ^ r_mul(a1, 3) ^ a2 ^ a3;
                o[127 - 8 * (4 * c + 1) -: 8] = a0 ^ r_mul(a1, 2) ^ r_mul(a2, 3) ^ a3;
                o[127 - 8 * (4 * c + 2) -: 8] = a0 ^ a1 ^ r_mul(a2, 2) ^ r_mul(a3, 3);
                o[127 - 8 * (4 * c + 3) -: 8] = r_mul(a0, 3) ^ a1 ^ a2 ^ r_mul(a3, 2);
            end
        end
        return o ^ k;
    endfunction

    function automatic logic [127:0] r_next_key(input logic [127:0] k, input logic [7:0] rc);
        logic [31:0] w0, w1, w2, w3, t;
        w0 = k[127:96]; w1 = k[95:64]; w2 = k[63:32]; w3 = k[31:0];
        t = {r_sbox(w3[23:16]) ^ rc, r_sbox(w3[15:8]), r_sbox(w3[7:0]), r_sbox(w3[31:24])};
        w0 = w0 ^ t; w1 = w1 ^ w0; w2 = w2 ^ w1; w3 = w3 ^ w2;
        return {w0, w1, w2, w3};
    endfunction

    // ---------- check helpers ----------
    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    endtask

    // one block through, checking exact timing, flag and data
    task automatic one_pass(input string req, input logic [127:0] s, input logic [127:0] w,
                            input logic [127:0] k, input bit first, input bit last,
                            output logic [127:0] got);
        @(negedge clk);
        in_valid = 1'b1; in_last = last; in_first = first;
        in_state = s; in_white = w; in_key = k;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_first = 1'b0;
        in_state = '0; in_white = '0; in_key = '0;
        repeat (4) @(negedge clk);
        chk({req, " R2 not early"}, 128'(out_valid), 128'd0);
        @(negedge clk);
        chk({req, " R2 on time"}, 128'(out_valid), 128'd1);
        chk({req, " R3 last flag"}, 128'(out_last), 128'(last));
        got = out_state;
    endtask

    task automatic t_reset();
        chk("R1 valid in reset", 128'(out_valid), 128'd0);
        chk("R1 state in reset", out_state, 128'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", 128'(out_valid), 128'd0);
        chk("R1 last after release", 128'(out_last), 128'd0);
        chk("R1 state after release", out_state, 128'd0);
    endtask

    task automatic t_normal_round();
        logic [127:0] g;
        one_pass("R4", 128'h00102030405060708090a0b0c0d0e0f0, 128'h0,
                 128'hd6aa74fdd2af72fadaa678f1d6ab76fe, 1'b0, 1'b0, g);
        chk("R4 normal round", g, 128'h89d810e8855ace682d1843d8cb128fe4);
    endtask

    task automatic t_last_round();
        logic [127:0] g;
        one_pass("R5", 128'h00102030405060708090a0b0c0d0e0f0, 128'h0, 128'h0, 1'b0, 1'b1, g);
        chk("R5 final round bypass", g, 128'h6353e08c0960e104cd70b751bacad0e7);
    endtask

    task automatic t_whiten();
        logic [127:0] g;
        one_pass("R6", 128'h00112233445566778899aabbccddeeff,
                 128'h000102030405060708090a0b0c0d0e0f,
                 128'hd6aa74fdd2af72fadaa678f1d6ab76fe, 1'b1, 1'b0, g);
        chk("R6 whitening applied", g, 128'h89d810e8855ace682d1843d8cb128fe4);
        one_pass("R7", 128'h00102030405060708090a0b0c0d0e0f0, {4{32'hffffffff}},
                 128'hd6aa74fdd2af72fadaa678f1d6ab76fe, 1'b0, 1'b0, g);
        chk("R7 whitening ignored", g, 128'h89d810e8855ace682d1843d8cb128fe4);
    endtask

    task automatic t_burst();
        logic [127:0] st [6];
        logic [127:0] ky [6];
        for (int j = 0; j < 6; j++) begin
            st[j] = {16{8'(8'h11 * j + 8'h05)}} ^ {4{32'(32'h01234567 * (j + 1))}};
            ky[j] = {4{32'(32'h9e3779b9 * (j + 3))}};
        end
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            in_valid = 1'b1; in_first = 1'b0; in_last = (j == 2);
            in_state = st[j]; in_key = ky[j]; in_white = '0;
        end
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0; in_state = '0; in_key = '0;
            chk($sformatf("R8 burst valid %0d", j), 128'(out_valid), 128'd1);
            chk($sformatf("R8 burst data %0d", j), out_state, r_round(st[j], ky[j], j == 2));
            chk($sformatf("R3 burst last %0d", j), 128'(out_last), 128'(j == 2));
        end
        @(negedge clk);
        chk("R8 burst end", 128'(out_valid), 128'd0);
    endtask

    task automatic t_full_cipher();
        logic [127:0] rk, s, g;
        logic [7:0]   rc;
        rk = 128'h000102030405060708090a0b0c0d0e0f;
        s  = 128'h00112233445566778899aabbccddeeff;
        rc = 8'h01;
        for (int i = 1; i <= 10; i++) begin
            logic [127:0] prev;
            prev = rk;
            rk = r_next_key(rk, rc);
            rc = r_mul(rc, 8'h02);
            one_pass($sformatf("R9 pass %0d", i), s, prev, rk, i == 1, i == 10, g);
            s = g;
        end
        chk("R9 ten-pass ciphertext", s, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_normal_round();
        t_last_round();
        t_whiten();
        t_burst();
        t_full_cipher();
        repeat (2) @(negedge clk);
        summary();
    end
endmodule